// File: doc/BRIEF.md
# Alarm Match and Interrupt Unit for a BCD Calendar Clock

This block sits beside a running calendar clock. On every once-per-second update strobe it compares the current BCD month, day of month, hours, minutes and seconds with a set of programmed alarm values. A five-bit repeat code chooses which of those fields have to agree. When they agree, a sticky alarm flag is set. An active-low interrupt request is driven from that flag, subject to the enable bits, the battery-mode state and the position of the register address pointer.

The flag is cleared by a register read that targets the flag register address. The interrupt pin is held back while the address pointer rests on that address, and it is released as soon as the pointer moves away. The timekeeping counters, the serial bus and the square-wave generator are outside this block.

Top module: `alarm_match_irq`

## Requirements
- R1: After reset, and until the first match, `alarm_flag_o` is 0 and `irq_n_o` is 1.
- R2: The repeat code `rpt_code_i` selects which fields are compared. 5'b11111 compares no field, 5'b11110 compares seconds, 5'b11100 compares minutes and seconds, 5'b11000 compares hours, minutes and seconds, 5'b10000 adds the date, and 5'b00000 adds the month as well. The flag is set only when all selected fields are equal.
- R3: Any repeat code outside the six listed in R2 behaves like 5'b11111: every strobe is a match.
- R4: A match is evaluated only in a cycle with `tick_i` high, and sets `alarm_flag_o` at that clock edge. Without a strobe the flag never rises. Once set, the flag stays set until it is cleared.
- R5: A cycle with `rd_strobe_i` high and `rd_addr_i` equal to `FLAG_ADDR` (default 5'h0F) clears the flag and the interrupt at its edge. `alarm_flag_o` still reads 1 during that cycle. A read of any other address leaves the flag unchanged.
- R6: `irq_n_o` goes low one edge after the flag is 1, `flag_en_i` is 1 and `sqw_en_i` is 0. If `flag_en_i` is 0 or `sqw_en_i` is 1, it stays high.
- R7: While `ptr_i` equals `FLAG_ADDR`, `irq_n_o` stays high, but a match still sets the flag. `irq_n_o` falls at the first edge after the pointer moves to another address.
- R8: While `on_battery_i` is 1, the interrupt is driven only if both `batt_alarm_en_i` and `flag_en_i` are 1.
- R9: If a match and a clearing read of the flag register occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Once-per-second update strobe |
| now_month_i | input | FIELD_W | Current month, BCD |
| now_date_i | input | FIELD_W | Current day of month, BCD |
| now_hour_i | input | FIELD_W | Current hours, BCD |
| now_min_i | input | FIELD_W | Current minutes, BCD |
| now_sec_i | input | FIELD_W | Current seconds, BCD |
| alm_month_i | input | FIELD_W | Alarm month, BCD |
| alm_date_i | input | FIELD_W | Alarm day of month, BCD |
| alm_hour_i | input | FIELD_W | Alarm hours, BCD |
| alm_min_i | input | FIELD_W | Alarm minutes, BCD |
| alm_sec_i | input | FIELD_W | Alarm seconds, BCD |
| rpt_code_i | input | 5 | Repeat-mode code |
| flag_en_i | input | 1 | Allows the flag to drive the interrupt |
| sqw_en_i | input | 1 | Square wave owns the pin; blocks the interrupt |
| batt_alarm_en_i | input | 1 | Allows the interrupt in battery mode |
| on_battery_i | input | 1 | Running from the backup supply |
| rd_strobe_i | input | 1 | Register read in this cycle |
| rd_addr_i | input | ADDR_W | Address of that read |
| ptr_i | input | ADDR_W | Current register address pointer |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
A wrong field mask in the repeat decoder shows up at the next strobe. Either the flag stays low when one field differs only in an unselected position, or it rises when a selected field differs. Such a fault is therefore visible one edge after the strobe. A faulty clear, gate or pointer hold shows on `irq_n_o` or `alarm_flag_o` one edge after the read, enable change or pointer move that should have acted. A flag that loses its stickiness shows on the first idle cycle after it was set.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int RPT_W      = 5;

  // Field slot order inside the packed field vectors
  typedef enum int unsigned {
    F_SEC   = 0,
    F_MIN   = 1,
    F_HOUR  = 2,
    F_DATE  = 3,
    F_MONTH = 4
  } field_e;

  localparam logic [RPT_W-1:0] RPT_EVERY_SEC   = 5'b11111;
  localparam logic [RPT_W-1:0] RPT_EVERY_MIN   = 5'b11110;
  localparam logic [RPT_W-1:0] RPT_EVERY_HOUR  = 5'b11100;
  localparam logic [RPT_W-1:0] RPT_EVERY_DAY   = 5'b11000;
  localparam logic [RPT_W-1:0] RPT_EVERY_MONTH = 5'b10000;
  localparam logic [RPT_W-1:0] RPT_EVERY_YEAR  = 5'b00000;

  typedef logic [NUM_FIELDS-1:0] field_mask_t;
endpackage

// File: rtl/alarm_rpt_decode.sv
module alarm_rpt_decode
  import alarm_pkg::*;
(
  input  logic [RPT_W-1:0] rpt_code_i,
  output field_mask_t      mask_o
);
  always_comb begin
    mask_o = '0;
    unique case (rpt_code_i)
      RPT_EVERY_MIN:   mask_o = field_mask_t'(1) << F_SEC;
      RPT_EVERY_HOUR:  mask_o = (field_mask_t'(1) << F_SEC) | (field_mask_t'(1) << F_MIN);
      RPT_EVERY_DAY:   mask_o = (field_mask_t'(1) << F_SEC) | (field_mask_t'(1) << F_MIN)
                              | (field_mask_t'(1) << F_HOUR);
      RPT_EVERY_MONTH: mask_o = (field_mask_t'(1) << F_SEC) | (field_mask_t'(1) << F_MIN)
                              | (field_mask_t'(1) << F_HOUR) | (field_mask_t'(1) << F_DATE);
      RPT_EVERY_YEAR:  mask_o = '1;
      default:         mask_o = '0; // once per second, also for unlisted codes
    endcase
  end
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import alarm_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                               tick_i,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_i,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_i,
  input  field_mask_t                        mask_i,
  output logic                               hit_o
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign field_ok[g] = !mask_i[g] || (now_i[g] == alm_i[g]);
  end

  assign hit_o = tick_i && (&field_ok);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] FLAG_A    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              rd_strobe_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              flag_en_i,
  input  logic              sqw_en_i,
  input  logic              batt_alarm_en_i,
  input  logic              on_battery_i,
  output logic              flag_o,
  output logic              irq_n_o
);
  logic flag_q, flag_d, flag_ce;
  logic irq_q, irq_d;
  logic flag_clr, pin_ok;

  always_comb begin
    flag_clr = rd_strobe_i && (rd_addr_i == FLAG_A);
    flag_ce  = hit_i || flag_clr;
    flag_d   = hit_i;                       // set has priority over clear
    pin_ok   = flag_en_i && !sqw_en_i
            && (!on_battery_i || batt_alarm_en_i)
            && (ptr_i != FLAG_A);
    irq_d    = (flag_ce ? flag_d : flag_q) && pin_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (flag_ce) flag_q <= flag_d;
      irq_q <= irq_d;
    end
  end

  assign flag_o  = flag_q;
  assign irq_n_o = !irq_q;
endmodule

// File: rtl/alarm_match_irq.sv
module alarm_match_irq
  import alarm_pkg::*;
#(
  parameter int          FIELD_W   = 8,
  parameter int          ADDR_W    = 5,
  parameter int unsigned FLAG_ADDR = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [FIELD_W-1:0] now_month_i,
  input  logic [FIELD_W-1:0] now_date_i,
  input  logic [FIELD_W-1:0] now_hour_i,
  input  logic [FIELD_W-1:0] now_min_i,
  input  logic [FIELD_W-1:0] now_sec_i,
  input  logic [FIELD_W-1:0] alm_month_i,
  input  logic [FIELD_W-1:0] alm_date_i,
  input  logic [FIELD_W-1:0] alm_hour_i,
  input  logic [FIELD_W-1:0] alm_min_i,
  input  logic [FIELD_W-1:0] alm_sec_i,
  input  logic [4:0]         rpt_code_i,
  input  logic               flag_en_i,
  input  logic               sqw_en_i,
  input  logic               batt_alarm_en_i,
  input  logic               on_battery_i,
  input  logic               rd_strobe_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [ADDR_W-1:0]  ptr_i,
  output logic               alarm_flag_o,
  output logic               irq_n_o
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

  // Reset asserts at once, releases on the second clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_vec, alm_vec;
  field_mask_t                        fld_mask;
  logic                               match_hit;

  assign now_vec = {now_month_i, now_date_i, now_hour_i, now_min_i, now_sec_i};
  assign alm_vec = {alm_month_i, alm_date_i, alm_hour_i, alm_min_i, alm_sec_i};

  alarm_rpt_decode u_dec (
    .rpt_code_i (rpt_code_i),
    .mask_o     (fld_mask)
  );

  alarm_field_cmp #(.FIELD_W(FIELD_W)) u_cmp (
    .tick_i (tick_i),
    .now_i  (now_vec),
    .alm_i  (alm_vec),
    .mask_i (fld_mask),
    .hit_o  (match_hit)
  );

  alarm_irq_ctrl #(.ADDR_W(ADDR_W), .FLAG_A(FLAG_A)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .hit_i           (match_hit),
    .rd_strobe_i     (rd_strobe_i),
    .rd_addr_i       (rd_addr_i),
    .ptr_i           (ptr_i),
    .flag_en_i       (flag_en_i),
    .sqw_en_i        (sqw_en_i),
    .batt_alarm_en_i (batt_alarm_en_i),
    .on_battery_i    (on_battery_i),
    .flag_o          (alarm_flag_o),
    .irq_n_o         (irq_n_o)
  );
endmodule

// File: rtl/alarm_match_irq_chk.sv
module alarm_match_irq_chk #(
  parameter int                ADDR_W = 5,
  parameter logic [ADDR_W-1:0] FLAG_A = '0
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              hit,
  input logic              tick_i,
  input logic              rd_strobe_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic              flag_en_i,
  input logic              sqw_en_i,
  input logic              batt_alarm_en_i,
  input logic              on_battery_i,
  input logic              alarm_flag_o,
  input logic              irq_n_o
);
  // R4: a comparator hit sets the flag at the next edge
  a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_ok_n)
    hit |=> alarm_flag_o);

  // R4: no hit, no rise
  a_r4_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!hit && !alarm_flag_o) |=> !alarm_flag_o);

  // R4: hits only on strobe cycles
  a_r4_hit_needs_tick: assert property (@(posedge clk) disable iff (!rst_ok_n)
    hit |-> tick_i);

  // R5: clearing read without a new hit empties flag and pin
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (rd_strobe_i && rd_addr_i == FLAG_A && !hit) |=> (!alarm_flag_o && irq_n_o));

  // R6: pin blocked by enables
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!flag_en_i || sqw_en_i) |=> irq_n_o);

  // R7: pointer on the flag register holds the pin off
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ptr_i == FLAG_A) |=> irq_n_o);

  // R8: battery mode requires its own enable
  a_r8_battery_gate: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (on_battery_i && !batt_alarm_en_i) |=> irq_n_o);

  // R6: an active pin always has a set flag behind it
  a_r6_irq_implies_flag: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !irq_n_o |-> alarm_flag_o);
endmodule

bind alarm_match_irq alarm_match_irq_chk #(.ADDR_W(ADDR_W), .FLAG_A(FLAG_A)) u_chk (
  .clk             (clk),
  .rst_ok_n        (rst_sync_n),
  .hit             (match_hit),
  .tick_i          (tick_i),
  .rd_strobe_i     (rd_strobe_i),
  .rd_addr_i       (rd_addr_i),
  .ptr_i           (ptr_i),
  .flag_en_i       (flag_en_i),
  .sqw_en_i        (sqw_en_i),
  .batt_alarm_en_i (batt_alarm_en_i),
  .on_battery_i    (on_battery_i),
  .alarm_flag_o    (alarm_flag_o),
  .irq_n_o         (irq_n_o)
);

// File: tb/tb_alarm_match_irq.sv
module tb_alarm_match_irq;
  localparam int FW = 8;
  localparam int AW = 5;
  localparam logic [AW-1:0] FLAG = 5'h0F;
  localparam logic [39:0] ALM = 40'h06_15_12_30_45; // month date hour min sec
  localparam int NV = 14;
  // {rpt code, now fields, expected flag}
  localparam logic [45:0] VECS [0:NV-1] = '{
    {5'b11111, 40'h01_01_01_01_01, 1'b1},
    {5'b11110, 40'h01_01_01_01_45, 1'b1},
    {5'b11110, 40'h06_15_12_30_44, 1'b0},
    {5'b11100, 40'h01_01_01_30_45, 1'b1},
    {5'b11100, 40'h06_15_12_31_45, 1'b0},
    {5'b11000, 40'h01_01_12_30_45, 1'b1},
    {5'b11000, 40'h06_15_13_30_45, 1'b0},
    {5'b10000, 40'h01_15_12_30_45, 1'b1},
    {5'b10000, 40'h06_16_12_30_45, 1'b0},
    {5'b00000, 40'h06_15_12_30_45, 1'b1},
    {5'b00000, 40'h07_15_12_30_45, 1'b0},
    {5'b10101, 40'h01_01_01_01_01, 1'b1},
    {5'b01111, 40'h02_02_02_02_02, 1'b1},
    {5'b11101, 40'h03_03_03_03_03, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic [FW-1:0] n_mo, n_dt, n_hr, n_mi, n_se;
  logic [FW-1:0] a_mo, a_dt, a_hr, a_mi, a_se;
  logic [4:0] rpt;
  logic fen, sqw, ben, batt, rd;
  logic [AW-1:0] raddr, ptr;
  logic flag, irq_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alarm_match_irq dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .now_month_i(n_mo), .now_date_i(n_dt), .now_hour_i(n_hr),
    .now_min_i(n_mi), .now_sec_i(n_se),
    .alm_month_i(a_mo), .alm_date_i(a_dt), .alm_hour_i(a_hr),
    .alm_min_i(a_mi), .alm_sec_i(a_se),
    .rpt_code_i(rpt), .flag_en_i(fen), .sqw_en_i(sqw),
    .batt_alarm_en_i(ben), .on_battery_i(batt),
    .rd_strobe_i(rd), .rd_addr_i(raddr), .ptr_i(ptr),
    .alarm_flag_o(flag), .irq_n_o(irq_n)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobe();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic clear_flag();
    rd = 1'b1; raddr = FLAG; step(); rd = 1'b0; raddr = '0;
  endtask

  function automatic bit listed(input logic [4:0] c);
    return c == 5'b11111 || c == 5'b11110 || c == 5'b11100 ||
           c == 5'b11000 || c == 5'b10000 || c == 5'b00000;
  endfunction

  initial begin
    rst_n = 1'b0; tick = 1'b0; rd = 1'b0; raddr = '0; ptr = '0;
    fen = 1'b1; sqw = 1'b0; ben = 1'b0; batt = 1'b0; rpt = 5'b00000;
    {a_mo, a_dt, a_hr, a_mi, a_se} = ALM;
    {n_mo, n_dt, n_hr, n_mi, n_se} = 40'h01_01_01_01_01;
    repeat (3) step();
    check("R1 flag in reset", flag, 1'b0);
    check("R1 irq_n in reset", irq_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) step();
    check("R1 flag after reset", flag, 1'b0);
    check("R1 irq_n after reset", irq_n, 1'b1);

    // Vector walk: R2 for listed codes, R3 for the rest
    for (int i = 0; i < NV; i++) begin
      automatic logic [45:0] v = VECS[i];
      automatic string tg = listed(v[45:41]) ? "R2" : "R3";
      rpt = v[45:41];
      {n_mo, n_dt, n_hr, n_mi, n_se} = v[40:1];
      strobe();
      check($sformatf("%s vec %0d flag", tg, i), flag, v[0]);
      check($sformatf("%s vec %0d irq_n", tg, i), irq_n, !v[0]);
      clear_flag();
    end

    // R4: full match without strobe, then with strobe, then sticky
    rpt = 5'b00000; {n_mo, n_dt, n_hr, n_mi, n_se} = ALM;
    repeat (4) step();
    check("R4 no strobe no flag", flag, 1'b0);
    strobe();
    check("R4 strobe sets flag", flag, 1'b1);
    {n_mo, n_dt, n_hr, n_mi, n_se} = 40'h01_01_01_01_02;
    repeat (5) step();
    check("R4 flag sticky", flag, 1'b1);

    // R5: other address does nothing, flag read clears
    rd = 1'b1; raddr = 5'h0E; step(); rd = 1'b0;
    check("R5 other read keeps flag", flag, 1'b1);
    check("R5 other read keeps irq", irq_n, 1'b0);
    rd = 1'b1; raddr = FLAG; #1;
    check("R5 flag reads 1 in access", flag, 1'b1);
    step(); rd = 1'b0; raddr = '0;
    check("R5 flag cleared", flag, 1'b0);
    check("R5 irq released", irq_n, 1'b1);

    // R6: enable gating
    rpt = 5'b11111; fen = 1'b0;
    strobe();
    check("R6 flag sets with enable off", flag, 1'b1);
    check("R6 no irq with enable off", irq_n, 1'b1);
    fen = 1'b1; sqw = 1'b1; step();
    check("R6 no irq with square wave", irq_n, 1'b1);
    sqw = 1'b0; step();
    check("R6 irq when gate opens", irq_n, 1'b0);
    clear_flag();

    // R7: pointer on flag address
    ptr = FLAG;
    strobe();
    check("R7 flag set under hold", flag, 1'b1);
    check("R7 irq held off", irq_n, 1'b1);
    step();
    check("R7 irq still held", irq_n, 1'b1);
    ptr = 5'h03; step();
    check("R7 irq after pointer moves", irq_n, 1'b0);
    clear_flag();

    // R8: battery mode
    batt = 1'b1; ben = 1'b0;
    strobe();
    check("R8 no irq without battery enable", irq_n, 1'b1);
    ben = 1'b1; step();
    check("R8 irq with battery enable", irq_n, 1'b0);
    fen = 1'b0; step();
    check("R8 battery enable alone not enough", irq_n, 1'b1);
    fen = 1'b1; batt = 1'b0; ben = 1'b0;
    clear_flag();
    check("R8 cleared before next", flag, 1'b0);

    // R9: set and clear in the same cycle
    tick = 1'b1; rd = 1'b1; raddr = FLAG;
    step();
    tick = 1'b0; rd = 1'b0; raddr = '0;
    check("R9 set wins over clear", flag, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule